// File: doc/BRIEF.md
# Backup-Battery Switchover Controller

This block chooses the source of a protected supply rail: the main supply or a backup battery. It takes synchronous comparator flags (main supply above the reset threshold, main supply above the battery voltage, main supply below an absolute floor) together with a manual switch request. From these it drives the rail-select control and a separate battery-mode status output. A mode register holds the rail choice. Entry into battery mode needs a real supply loss or an explicit request. A manual request stays latched until a supply loss and recovery cycle brings the rail back.

A freshness seal keeps a new battery off the rail until the product is first used. The seal is armed by a qualifying power-up of bounded length: the power-fail output is held low, the power-fail input is tied to the main supply, and the main supply stays above the threshold for a window measured in millisecond ticks. The seal is removed by the first rising edge of the system reset while the main supply is present.

All outputs are registered. A flag change sampled at clock edge k shows on the outputs right after edge k.

Top module: `sw_switchover`

## Requirements
- R1: While and after reset, `rail_on_bat` and `bat_status` are 0 and the seal is clear: a later supply loss connects the battery.
- R2: With the seal clear, `main_ok`=0 and `main_gt_bat`=0 sampled at an edge put the rail on the battery after that edge.
- R3: The rail never moves from main to battery because of supply flags while `main_gt_bat`=1, unless `main_lt_min`=1 or `man_sw`=1.
- R4: From battery mode entered by supply loss, the rail returns to main at the first edge where `main_ok`=1 or `main_gt_bat`=1 (with `main_lt_min`=0 and `man_sw`=0).
- R5: In main mode, `man_sw`=1 at an edge puts the rail on the battery after that edge.
- R6: In manually entered battery mode, `man_sw` has no effect. The rail stays on the battery while the supply is good, even after `man_sw` returns to 0.
- R7: `main_lt_min`=1 at an edge puts the rail on the battery after that edge, whatever the other flags, unless the seal is armed.
- R8: `bat_status` equals `rail_on_bat` in every cycle.
- R9: The seal arms at the edge where `main_ok` falls. This happens only if, in the cycle before, `pf_out_low`, `pf_in_at_main` and `main_ok` were all 1 and the qualifying interval held between SEAL_MIN_MS and SEAL_MAX_MS `ms_tick` pulses inclusive. A shorter or longer interval leaves the seal clear.
- R10: While the seal is armed, the rail stays on main under any flags, including `main_lt_min`=1.
- R11: The seal clears on a rising edge of `sys_rst_n` sampled while `main_ok`=1. A rising edge while `main_ok`=0 leaves it armed.
- R12: A manual latch ends only through supply loss then recovery. On recovery with `man_sw`=0 the rail returns to main. On recovery with `man_sw`=1 it stays on the battery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| main_ok | input | 1 | Main supply above reset threshold |
| main_gt_bat | input | 1 | Main supply above battery voltage |
| main_lt_min | input | 1 | Main supply below absolute floor |
| man_sw | input | 1 | Manual request for battery mode |
| pf_out_low | input | 1 | Power-fail output held low |
| pf_in_at_main | input | 1 | Power-fail input tied to main supply |
| sys_rst_n | input | 1 | System reset level, active low |
| rail_on_bat | output | 1 | Rail-select control, 1 = battery |
| bat_status | output | 1 | Battery-mode status |

## Verification
The hardest state to reach is an armed seal. To get there, the three power-up conditions must be held together for an exact number of millisecond ticks, and then the main supply must drop in the very next cycle. The bench drives one tick per cycle and repeats the power-up for interval lengths just inside and just outside both bounds. After each attempt it probes the rail with a supply loss and with the floor flag. It then removes the seal with a system-reset edge, first without and then with the main supply present. The mode logic is covered by sweeping all sixteen flag combinations from each of the three reachable modes.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    MODE_MAIN     = 2'd0,
    MODE_AUTO_BAT = 2'd1,
    MODE_MAN_BAT  = 2'd2
  } sw_mode_e;
endpackage

// File: rtl/sw_seal_ctl.sv
module sw_seal_ctl #(
  parameter int SEAL_MIN_MS = 5,
  parameter int SEAL_MAX_MS = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic main_ok,
  input  logic pf_out_low,
  input  logic pf_in_at_main,
  input  logic sys_rst_n,
  output logic seal_q,
  output logic seal_d
);
  localparam int CNT_W = $clog2(SEAL_MAX_MS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SEAL_MAX_MS + 1);
  localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(SEAL_MIN_MS);
  localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(SEAL_MAX_MS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             qual, qual_q;
  logic             srst_q;
  logic             in_win, arm, clr;

  assign qual   = pf_out_low & pf_in_at_main & main_ok;
  assign cnt_en = ~qual | ms_tick;
  assign in_win = (cnt_q >= CNT_LO) && (cnt_q <= CNT_HI);
  assign arm    = qual_q & ~main_ok & in_win;
  assign clr    = sys_rst_n & ~srst_q & main_ok;

  always_comb begin
    if (!qual)                 cnt_d = '0;
    else if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  always_comb begin
    if (clr)      seal_d = 1'b0;
    else if (arm) seal_d = 1'b1;
    else          seal_d = seal_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
      srst_q <= 1'b0;
      seal_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      qual_q <= qual;
      srst_q <= sys_rst_n;
      seal_q <= seal_d;
    end
  end
endmodule

// File: rtl/sw_mode_fsm.sv
module sw_mode_fsm
  import sw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     main_ok,
  input  logic     main_gt_bat,
  input  logic     main_lt_min,
  input  logic     man_sw,
  input  logic     seal_q,
  output sw_mode_e mode_q,
  output sw_mode_e mode_d
);
  logic lost;

  assign lost = main_lt_min | (~main_ok & ~main_gt_bat);

  always_comb begin
    mode_d = mode_q;
    if (seal_q) begin
      mode_d = MODE_MAIN;
    end else begin
      case (mode_q)
        MODE_MAIN: begin
          if (lost)        mode_d = MODE_AUTO_BAT;
          else if (man_sw) mode_d = MODE_MAN_BAT;
        end
        MODE_AUTO_BAT: begin
          if (!lost) mode_d = man_sw ? MODE_MAN_BAT : MODE_MAIN;
        end
        MODE_MAN_BAT: begin
          if (lost) mode_d = MODE_AUTO_BAT;
        end
        default: mode_d = MODE_MAIN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_MAIN;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/sw_switchover.sv
module sw_switchover
  import sw_pkg::*;
#(
  parameter int SEAL_MIN_MS = 5,
  parameter int SEAL_MAX_MS = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic main_ok,
  input  logic main_gt_bat,
  input  logic main_lt_min,
  input  logic man_sw,
  input  logic pf_out_low,
  input  logic pf_in_at_main,
  input  logic sys_rst_n,
  output logic rail_on_bat,
  output logic bat_status
);
  logic     seal_q, seal_d;
  sw_mode_e mode_q, mode_d;
  logic     status_q;

  sw_seal_ctl #(
    .SEAL_MIN_MS (SEAL_MIN_MS),
    .SEAL_MAX_MS (SEAL_MAX_MS)
  ) u_seal (
    .clk           (clk),
    .rst_n         (rst_n),
    .ms_tick       (ms_tick),
    .main_ok       (main_ok),
    .pf_out_low    (pf_out_low),
    .pf_in_at_main (pf_in_at_main),
    .sys_rst_n     (sys_rst_n),
    .seal_q        (seal_q),
    .seal_d        (seal_d)
  );

  sw_mode_fsm u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_ok     (main_ok),
    .main_gt_bat (main_gt_bat),
    .main_lt_min (main_lt_min),
    .man_sw      (man_sw),
    .seal_q      (seal_q),
    .mode_q      (mode_q),
    .mode_d      (mode_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= (mode_d != MODE_MAIN) & ~seal_d;
  end

  assign rail_on_bat = (mode_q != MODE_MAIN) & ~seal_q;
  assign bat_status  = status_q;
endmodule

// File: rtl/sw_switchover_chk.sv
module sw_switchover_chk (
  input logic clk,
  input logic rst_n,
  input logic main_ok,
  input logic main_gt_bat,
  input logic main_lt_min,
  input logic man_sw,
  input logic rail_on_bat,
  input logic bat_status,
  input logic seal
);
  AST_STATUS_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    rail_on_bat == bat_status); // R8

  AST_AUTO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_on_bat && !$past(rail_on_bat) && !$past(man_sw) && !$past(main_lt_min))
    |-> (!$past(main_gt_bat) && !$past(main_ok))); // R3

  AST_MAN_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rail_on_bat && !seal && man_sw && main_ok) |=> rail_on_bat); // R5

  AST_SEAL_DISC: assert property (@(posedge clk) disable iff (!rst_n)
    seal |-> !bat_status); // R10

  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(main_lt_min) && !$past(seal) && !seal) |-> rail_on_bat); // R7
endmodule

bind sw_switchover sw_switchover_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .main_ok     (main_ok),
  .main_gt_bat (main_gt_bat),
  .main_lt_min (main_lt_min),
  .man_sw      (man_sw),
  .rail_on_bat (rail_on_bat),
  .bat_status  (bat_status),
  .seal        (seal_q)
);

// File: tb/sim_sw_switchover.sv
`timescale 1ns/1ps
module sim_sw_switchover;
  logic clk = 1'b0;
  logic rst_n, ms_tick, main_ok, main_gt_bat, main_lt_min, man_sw;
  logic pf_out_low, pf_in_at_main, sys_rst_n;
  logic rail_on_bat, bat_status;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #10 clk = ~clk;

  sw_switchover #(.SEAL_MIN_MS(5), .SEAL_MAX_MS(35)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .main_ok(main_ok),
    .main_gt_bat(main_gt_bat), .main_lt_min(main_lt_min), .man_sw(man_sw),
    .pf_out_low(pf_out_low), .pf_in_at_main(pf_in_at_main),
    .sys_rst_n(sys_rst_n), .rail_on_bat(rail_on_bat), .bat_status(bat_status)
  );

  // modes: 0 main, 1 battery after supply loss, 2 manual battery
  function automatic int exp_mode(int m, bit ok, bit gt, bit lt, bit man);
    bit loss = lt || (!ok && !gt);
    if (m == 0) return loss ? 1 : (man ? 2 : 0);
    if (m == 1) return loss ? 1 : (man ? 2 : 0);
    return loss ? 1 : 2;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(bit ok, bit gt, bit lt, bit man);
    main_ok = ok; main_gt_bat = gt; main_lt_min = lt; man_sw = man;
    @(posedge clk); #1;
  endtask

  task automatic goto_mode(int m);
    step(0, 0, 0, 0);
    step(1, 1, 0, 0);
    chk("R4 setup main", rail_on_bat, 1'b0);
    if (m == 1) begin
      step(0, 0, 0, 0);
      chk("R2 setup auto", rail_on_bat, 1'b1);
    end else if (m == 2) begin
      step(1, 1, 0, 1);
      step(1, 1, 0, 0);
      chk("R6 setup manual", rail_on_bat, 1'b1);
    end
  endtask

  task automatic seal_try(int n, bit armed);
    step(1, 1, 0, 0);
    pf_out_low = 1'b1; pf_in_at_main = 1'b1; ms_tick = 1'b1;
    for (int i = 0; i < n; i++) step(1, 1, 0, 0);
    ms_tick = 1'b0;
    step(0, 0, 0, 0);
    chk($sformatf("R9 window %0d", n), rail_on_bat, !armed);
    step(0, 0, 1, 0);
    chk($sformatf("R10 floor window %0d", n), rail_on_bat, !armed);
    pf_out_low = 1'b0; pf_in_at_main = 1'b0;
    step(1, 1, 0, 0);
    chk("R4 after seal try", rail_on_bat, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; main_ok = 1'b1; main_gt_bat = 1'b1;
    main_lt_min = 1'b0; man_sw = 1'b0; pf_out_low = 1'b0;
    pf_in_at_main = 1'b0; sys_rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rail in reset", rail_on_bat, 1'b0);
    chk("R1 status in reset", bat_status, 1'b0);
    rst_n = 1'b1;
    step(1, 1, 0, 0);
    chk("R1 rail after reset", rail_on_bat, 1'b0);
    step(0, 0, 0, 0);
    chk("R1 seal clear after reset", rail_on_bat, 1'b1);

    // exhaustive sweep: start mode x 16 flag patterns
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < 16; p++) begin
        bit ok = p[0], gt = p[1], lt = p[2], man = p[3];
        int em;
        goto_mode(m);
        step(ok, gt, lt, man);
        em = exp_mode(m, ok, gt, lt, man);
        chk($sformatf("R2/R3/R4/R5/R6/R7 mode %0d pat %0d", m, p),
            rail_on_bat, em != 0);
        chk("R8 status matches rail", bat_status, rail_on_bat);
      end
    end

    // R12: manual latch survives recovery with request high
    goto_mode(2);
    step(0, 0, 0, 0);
    step(1, 1, 0, 1);
    chk("R12 recover with request", rail_on_bat, 1'b1);
    step(1, 1, 0, 0);
    chk("R12 latch held", rail_on_bat, 1'b1);
    step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    chk("R12 recover without request", rail_on_bat, 1'b0);

    // R4: recovery via threshold alone
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R4 threshold first", rail_on_bat, 1'b0);

    // seal window bounds
    seal_try(4, 1'b0);
    seal_try(36, 1'b0);
    seal_try(35, 1'b1);
    // armed: reset rising edge without main keeps seal (R11)
    sys_rst_n = 1'b0; step(0, 0, 0, 0);
    sys_rst_n = 1'b1; step(0, 0, 0, 0);
    chk("R11 edge without main keeps seal", rail_on_bat, 1'b0);
    step(1, 1, 0, 1);
    chk("R10 manual ignored while sealed", rail_on_bat, 1'b0);
    sys_rst_n = 1'b0; step(1, 1, 0, 0);
    sys_rst_n = 1'b1; step(1, 1, 0, 0);
    step(0, 0, 0, 0);
    chk("R11 seal cleared with main", rail_on_bat, 1'b1);
    step(1, 1, 0, 0);
    seal_try(5, 1'b1);
    sys_rst_n = 1'b0; step(1, 1, 0, 0);
    sys_rst_n = 1'b1; step(1, 1, 0, 0);
    step(0, 0, 1, 0);
    chk("R7 floor after seal clear", rail_on_bat, 1'b1);
    chk("R8 status final", bat_status, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule